// File: doc/BRIEF.md
# Time-Base Watchdog and Fixed-Interval Timer

This block keeps a 64-bit free-running time base and a 32-bit timer control word. It watches two software-chosen bits of the time base. When the watchdog tap rises from 0 to 1, the watchdog sequence advances. When the fixed-interval tap rises, the fixed-interval event fires. Each tap is picked by a 6-bit selector. A 4-bit extension field forms the upper part of the selector and a 2-bit period field forms the lower part. Longer periods are reached by choosing more significant bits of the count.

The first unserviced watchdog time-out sets a pending flag. The watchdog interrupt follows that flag when it is enabled. A time-out that arrives while the flag is still set is a second time-out, and it carries out the action in the write-once reset-control field: nothing, a latched checkstop, or a one-cycle reset request. Software services both events by pulsing their clear inputs. A decrementer interrupt enable and an auto-reload enable are only stored and read back.

Top module: `tbase_timer`

## Requirements
- R1: After reset the time base is zero. It rises by exactly one on each clock edge where `cnt_en` is high and holds its value while `cnt_en` is low.
- R2: A write of `wr_data` while `wr_en` is high updates the control word, which reads back on `rd_data` from the next cycle. Layout, with Verilog bit indices: [31:30] watchdog period, [29:28] reset control, [27] watchdog interrupt enable, [26] decrementer interrupt enable, [25:24] fixed-interval period, [23] fixed-interval interrupt enable, [22] auto-reload enable, [20:17] watchdog extension, [16:13] fixed-interval extension. Bits 21 and 12:0 always read 0, whatever is written to them.
- R3: A tap selector S = {extension, period} (0..63) watches time-base bit 63−S. S = 0 is the most significant bit and S = 63 is bit 0.
- R4: An event occurs only on a 0-to-1 change of the selected bit between two consecutive time-base values. Holding a level, a 1-to-0 change, or a change of selector while the count is frozen causes no event.
- R5: A fixed-interval event sets a sticky flag one cycle after the rising tap value appears on `tb_value`. `fit_irq` equals the flag AND its enable. `fit_clr` clears the flag, but a coincident event wins.
- R6: A watchdog event while no time-out is pending sets the pending flag and takes no reset-control action. `wd_irq` equals the pending flag AND its enable. `wd_clr` clears the flag, but a coincident event wins.
- R7: A watchdog event while the pending flag is set, with reset control 01, sets `chkstop`. It then stays high until reset, even if the flag is cleared.
- R8: With reset control 10, each such second time-out produces `rst_req` high for exactly one cycle. With 00 or 11, second time-outs drive neither `rst_req` nor `chkstop`.
- R9: Reset control is 00 after reset. A write can change it only while it is 00. Once it is non-zero, writes leave it unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Time-base count enable |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| wd_clr | input | 1 | Clears the watchdog pending flag |
| fit_clr | input | 1 | Clears the fixed-interval flag |
| rd_data | output | 32 | Control word read value |
| tb_value | output | 64 | Current time base |
| wd_irq | output | 1 | Watchdog interrupt |
| fit_irq | output | 1 | Fixed-interval interrupt |
| chkstop | output | 1 | Latched checkstop request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
`tb_value` and `rd_data` change one edge after the count enable or write strobe is applied. Event flags, interrupts, `chkstop` and `rst_req` change one edge after the rising tap value appears on `tb_value`, so an event lags the counter by two edges. The bench model advances on the same edges, and its outputs are compared with the design's at every falling edge, so each result is checked exactly in the cycle it is due. Directed checks freeze or run the count for fixed windows and sample only after those windows have settled.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int REG_W = 32;
  localparam int PER_W = 2;
  localparam int EXT_W = 4;
  localparam int SEL_W = PER_W + EXT_W;
  localparam int TB_W  = 2 ** SEL_W;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_STOP  = 2'b01,
    ACT_RESET = 2'b10,
    ACT_RSVD  = 2'b11
  } wd_act_e;

  typedef struct packed {
    logic [PER_W-1:0] wper;
    wd_act_e          act;
    logic             wie;
    logic             die;
    logic [PER_W-1:0] fper;
    logic             fie;
    logic             are;
    logic [EXT_W-1:0] wext;
    logic [EXT_W-1:0] fext;
  } ctrl_t;

  function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c);
    logic [REG_W-1:0] r;
    r        = '0;
    r[31:30] = c.wper;
    r[29:28] = c.act;
    r[27]    = c.wie;
    r[26]    = c.die;
    r[25:24] = c.fper;
    r[23]    = c.fie;
    r[22]    = c.are;
    r[20:17] = c.wext;
    r[16:13] = c.fext;
    return r;
  endfunction
endpackage

// File: rtl/tbt_counter.sv
module tbt_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] tb_q,
  output logic [W-1:0] tb_prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q    <= '0;
      tb_prev <= '0;
    end else begin
      tb_prev <= tb_q;
      if (en) tb_q <= tb_q + W'(1);
    end
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> tb_q == $past(tb_q));
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    en |=> tb_q == $past(tb_q) + W'(1));
endmodule

// File: rtl/tbt_tap.sv
module tbt_tap #(
  parameter int W     = 64,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     tb_q,
  input  logic [W-1:0]     tb_prev,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam logic [SEL_W-1:0] TOP = SEL_W'(W - 1);

  logic [SEL_W-1:0] idx;

  always_comb begin
    idx = TOP - sel;
    hit = tb_q[idx] & ~tb_prev[idx];
  end

  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/tbt_wdog.sv
module tbt_wdog
  import tbt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hit,
  input  logic    clr,
  input  wd_act_e act,
  output logic    pend,
  output logic    chkstop,
  output logic    rst_req
);
  logic second;

  always_comb second = hit & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      chkstop <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      pend    <= hit | (pend & ~clr);
      rst_req <= second && (act == ACT_RESET);
      if (second && (act == ACT_STOP)) chkstop <= 1'b1;
    end
  end

  a_r7_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    chkstop |=> chkstop);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  a_r6_first_silent: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> !rst_req);
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              wd_clr,
  input  logic              fit_clr,
  output logic [REG_W-1:0]  rd_data,
  output logic [TB_W-1:0]   tb_value,
  output logic              wd_irq,
  output logic              fit_irq,
  output logic              chkstop,
  output logic              rst_req
);
  ctrl_t            ctrl;
  logic [TB_W-1:0]  tb_q;
  logic [TB_W-1:0]  tb_prev;
  logic [SEL_W-1:0] wsel;
  logic [SEL_W-1:0] fsel;
  logic             wd_hit;
  logic             fit_hit;
  logic             wd_pend;
  logic             fit_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.wper <= wr_data[31:30];
      if (ctrl.act == ACT_NONE) ctrl.act <= wd_act_e'(wr_data[29:28]);
      ctrl.wie  <= wr_data[27];
      ctrl.die  <= wr_data[26];
      ctrl.fper <= wr_data[25:24];
      ctrl.fie  <= wr_data[23];
      ctrl.are  <= wr_data[22];
      ctrl.wext <= wr_data[20:17];
      ctrl.fext <= wr_data[16:13];
    end
  end

  a_r9_act_locked: assert property (@(posedge clk) disable iff (rst)
    (ctrl.act != ACT_NONE) |=> $stable(ctrl.act));

  always_comb begin
    wsel = {ctrl.wext, ctrl.wper};
    fsel = {ctrl.fext, ctrl.fper};
  end

  tbt_counter #(.W(TB_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .tb_q(tb_q), .tb_prev(tb_prev)
  );

  tbt_tap #(.W(TB_W), .SEL_W(SEL_W)) u_wtap (
    .clk(clk), .rst(rst), .tb_q(tb_q), .tb_prev(tb_prev), .sel(wsel), .hit(wd_hit)
  );

  tbt_tap #(.W(TB_W), .SEL_W(SEL_W)) u_ftap (
    .clk(clk), .rst(rst), .tb_q(tb_q), .tb_prev(tb_prev), .sel(fsel), .hit(fit_hit)
  );

  tbt_wdog u_wdog (
    .clk(clk), .rst(rst), .hit(wd_hit), .clr(wd_clr), .act(ctrl.act),
    .pend(wd_pend), .chkstop(chkstop), .rst_req(rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) fit_flag <= 1'b0;
    else     fit_flag <= fit_hit | (fit_flag & ~fit_clr);
  end

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (fit_flag && !fit_clr) |=> fit_flag);

  always_comb begin
    rd_data  = pack_ctrl(ctrl);
    tb_value = tb_q;
    wd_irq   = wd_pend & ctrl.wie;
    fit_irq  = fit_flag & ctrl.fie;
  end
endmodule

// File: tb/sim_tbase_timer.sv
module sim_tbase_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wd_clr = 1'b0;
  logic        fit_clr = 1'b0;
  logic [31:0] rd_data;
  logic [63:0] tb_value;
  logic        wd_irq, fit_irq, chkstop, rst_req;

  always #10 clk = ~clk;

  tbase_timer u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_data(wr_data),
    .wd_clr(wd_clr), .fit_clr(fit_clr), .rd_data(rd_data), .tb_value(tb_value),
    .wd_irq(wd_irq), .fit_irq(fit_irq), .chkstop(chkstop), .rst_req(rst_req)
  );

  int n_run = 0;
  int n_fail = 0;
  bit cmp_on = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // MSB-first field numbering: field bit i sits at Verilog index 31-i
  function automatic logic [31:0] mkw(int wp, int wrc, int wie, int die, int fp,
                                      int fie, int are, int wpx, int fpx);
    logic [31:0] d;
    d        = '0;
    d[31:30] = 2'(wp);
    d[29:28] = 2'(wrc);
    d[27]    = 1'(wie);
    d[26]    = 1'(die);
    d[25:24] = 2'(fp);
    d[23]    = 1'(fie);
    d[22]    = 1'(are);
    d[20:17] = 4'(wpx);
    d[16:13] = 4'(fpx);
    return d;
  endfunction

  // behavioural reference model
  logic [63:0] m_tb = '0, m_old = '0;
  int m_wp = 0, m_wrc = 0, m_wie = 0, m_die = 0, m_fp = 0, m_fie = 0, m_are = 0;
  int m_wpx = 0, m_fpx = 0;
  bit m_pend = 0, m_flag = 0, m_cs = 0, m_rr = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_tb = '0; m_old = '0;
      m_wp = 0; m_wrc = 0; m_wie = 0; m_die = 0; m_fp = 0; m_fie = 0; m_are = 0;
      m_wpx = 0; m_fpx = 0;
      m_pend = 0; m_flag = 0; m_cs = 0; m_rr = 0;
    end else begin
      int wbit, fbit;
      bit wev, fev;
      wbit = 63 - (m_wpx * 4 + m_wp);
      fbit = 63 - (m_fpx * 4 + m_fp);
      wev  = m_tb[wbit] && !m_old[wbit];
      fev  = m_tb[fbit] && !m_old[fbit];
      m_rr = wev && m_pend && (m_wrc == 2);
      if (wev && m_pend && (m_wrc == 1)) m_cs = 1;
      m_pend = wev ? 1'b1 : (wd_clr ? 1'b0 : m_pend);
      m_flag = fev || (m_flag && !fit_clr);
      if (wr_en) begin
        m_wp  = int'(wr_data[31:30]);
        if (m_wrc == 0) m_wrc = int'(wr_data[29:28]);
        m_wie = int'(wr_data[27]);
        m_die = int'(wr_data[26]);
        m_fp  = int'(wr_data[25:24]);
        m_fie = int'(wr_data[23]);
        m_are = int'(wr_data[22]);
        m_wpx = int'(wr_data[20:17]);
        m_fpx = int'(wr_data[16:13]);
      end
      m_old = m_tb;
      if (cnt_en) m_tb = m_tb + 64'd1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R1 tb_value", tb_value, m_tb);
      chk("R2 rd_data", {32'd0, rd_data}, {32'd0, mkw(m_wp, m_wrc, m_wie, m_die, m_fp, m_fie, m_are, m_wpx, m_fpx)});
      chk("R5 fit_irq", 64'(fit_irq), 64'(m_flag && (m_fie != 0)));
      chk("R6 wd_irq", 64'(wd_irq), 64'(m_pend && (m_wie != 0)));
      chk("R7 chkstop", 64'(chkstop), 64'(m_cs));
      chk("R8 rst_req", 64'(rst_req), 64'(m_rr));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [31:0] d);
    wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    int pulses;
    logic [63:0] frozen;
    step(3);
    rst = 1'b0;
    // R1 R9: reset state
    chk("R1 reset tb", tb_value, 64'd0);
    chk("R9 reset ctrl", {32'd0, rd_data}, 64'd0);
    chk("R7 reset chkstop", 64'(chkstop), 64'd0);
    cmp_on = 1;

    // R2: layout, reserved bits written as ones read back zero
    write(mkw(2, 0, 1, 1, 3, 1, 1, 15, 15) | 32'h0020_1FFF);
    chk("R2 readback", {32'd0, rd_data}, {32'd0, mkw(2, 0, 1, 1, 3, 1, 1, 15, 15)});
    chk("R2 reserved zero", 64'({rd_data[21], rd_data[12:0]}), 64'd0);

    // R3 R5 R6: fixed interval on bit 0, watchdog on bit 1
    cnt_en = 1'b1;
    step(6);
    chk("R5 fit_irq set", 64'(fit_irq), 64'd1);
    chk("R6 wd_irq set", 64'(wd_irq), 64'd1);

    // R5 clear, R4 selector change while frozen
    cnt_en = 1'b0; fit_clr = 1'b1;
    step(2);
    fit_clr = 1'b0;
    step(2);
    chk("R5 fit cleared", 64'(fit_irq), 64'd0);
    write(mkw(2, 0, 1, 1, 2, 1, 1, 15, 15));
    step(2);
    write(mkw(2, 0, 1, 1, 3, 1, 1, 15, 15));
    step(3);
    chk("R4 no event on selector change", 64'(fit_irq), 64'd0);

    // R8: action 00 gives nothing on second time-outs
    cnt_en = 1'b1;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (rst_req || chkstop) pulses++; end
    chk("R8 none action silent", 64'(pulses), 64'd0);

    // R8: action 10 gives reset pulses
    write(mkw(2, 2, 1, 1, 3, 1, 1, 15, 15));
    pulses = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (rst_req) pulses++; end
    chk("R8 reset pulses seen", 64'(pulses > 0), 64'd1);
    chk("R8 no checkstop", 64'(chkstop), 64'd0);

    // R9: locked field
    write(mkw(2, 1, 1, 1, 3, 1, 1, 15, 15));
    chk("R9 locked vs 01", 64'(rd_data[29:28]), 64'd2);
    write(mkw(2, 0, 1, 1, 3, 1, 1, 15, 15));
    chk("R9 locked vs 00", 64'(rd_data[29:28]), 64'd2);

    // R1: hold while disabled
    cnt_en = 1'b0;
    step(2);
    frozen = tb_value;
    step(4);
    chk("R1 hold", tb_value, frozen);

    // R3: selector 0 watches the MSB, which never rises here
    rst = 1'b1; step(2); rst = 1'b0;
    write(mkw(0, 1, 0, 0, 0, 0, 0, 0, 0));
    wd_clr = 1'b1; step(1); wd_clr = 1'b0;
    cnt_en = 1'b1;
    step(40);
    chk("R3 msb tap quiet", 64'(chkstop), 64'd0);

    // R7: selector 63 watches bit 0; second time-out latches checkstop
    write(mkw(3, 1, 0, 0, 0, 0, 0, 15, 0));
    step(10);
    chk("R7 checkstop set", 64'(chkstop), 64'd1);
    chk("R6 wd_irq gated off", 64'(wd_irq), 64'd0);
    cnt_en = 1'b0; wd_clr = 1'b1;
    step(3);
    wd_clr = 1'b0;
    step(1);
    chk("R7 checkstop sticky", 64'(chkstop), 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule